// File: doc/BRIEF.md
# SPI Slave Framebuffer Command Engine

This block lets one external module, acting as SPI master in mode 0, reach a 512-byte lighting framebuffer through single-byte commands. The command set extends the usual serial SRAM read and write with a few extra operations. After chip select falls, the first byte is an opcode. The bytes that follow carry addresses, arguments or data, depending on the opcode.

The engine handles three kinds of access:
- Burst writes and reads that step through the framebuffer one byte at a time.
- A persistent "next location" pointer that a read-next command consumes.
- Fixed identification bytes for slot location and version queries.

Takeover and power-control requests are passed to ports for outside logic. The framebuffer is an external synchronous memory with one cycle of read latency.

All SPI inputs are oversampled by the system clock through two-flop synchronizers. SCLK must therefore stay low and high for at least 8 system clocks each.

Top module: `spi_fb_engine`

## Requirements
- R1: After reset, the outputs are `miso_o`=0, `mem_we_o`=0 and `takeover_req_o`=0, and both power buses are off.
- R2: Opcode 0x02 is followed by an address sent as a high byte and then a low byte. Only the low 9 bits of the address are used. Each further full data byte is written to the current address with a single-clock `mem_we_o` pulse, and the address then increments.
- R3: Opcode 0x03 is followed by a two-byte address, high byte first, with only the low 9 bits used. The engine then returns framebuffer bytes starting at that address, incrementing after each byte. Address 511 is followed by address 0; the same wrap applies to writes.
- R4: Opcode 0x07 is followed by a two-byte address, which loads the next-location pointer. Opcode 0x04 takes no argument and returns bytes starting at the pointer. The pointer advances by one for each byte returned and keeps its value across transactions.
- R5: Opcode 0x06 returns one byte {4'b0000, SLOT_ID[2:0], SLOT_IS_OUT}. Every later byte in the transaction is 0x00.
- R6: Opcode 0x08 returns PROTO_VER, FW_VER[15:8], FW_VER[7:0] and HW_REV, in that order, and then 0x00.
- R7: Opcode 0x09 is followed by a channel byte, where 0 means the native channel. The engine raises a one-clock `takeover_req_o` with `takeover_chan_o` holding the channel byte. It samples `takeover_result_i` in the clock where the request is high and returns that value as the next byte (0 = success).
- R8: Opcode 0x0B is followed by one argument byte. Bit 0 of that byte selects the bus (0 = A, 1 = B) and bit 1 gives its new state (1 = on). The other bus keeps its state.
- R9: The following opcodes cause no memory write, no takeover request and no power change: 0x00 (no operation), the reserved 0x01 and 0x05, and any undefined opcode. `miso_o` stays 0 until chip select is released.
- R10: Raising chip select aborts the current command and discards any partial byte. The next transaction starts again with an opcode byte.
- R11: MISO is 0 during opcode, address and argument bytes. MOSI is sampled on the rising SCLK edge and MISO changes after the falling edge, most significant bit first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sclk_i | input | 1 | SPI clock from master, idle low |
| cs_ni | input | 1 | SPI chip select, active low |
| mosi_i | input | 1 | Serial data from master |
| miso_o | output | 1 | Serial data to master |
| mem_addr_o | output | ADDR_W | Framebuffer address |
| mem_wdata_o | output | 8 | Framebuffer write data |
| mem_we_o | output | 1 | Framebuffer write enable, one clock per byte |
| mem_rdata_i | input | 8 | Framebuffer read data, one clock after address |
| takeover_req_o | output | 1 | One-clock takeover request |
| takeover_chan_o | output | 8 | Requested channel, 0 = native |
| takeover_result_i | input | 8 | Takeover result, 0 = success |
| bus_a_on_o | output | 1 | Power bus A state |
| bus_b_on_o | output | 1 | Power bus B state |

## Verification
The bench builds the engine with ADDR_W=9, SLOT_ID=3, SLOT_IS_OUT=1, PROTO_VER=1, FW_VER=0x02A5 and HW_REV=3. With these values the location byte is 0x07, and each of the four version bytes differs from the others and from zero, so any reordering shows up. The 9-bit address lets a burst starting at 0x1FE cross the 511-to-0 wrap in four bytes. A high address byte of 0x03 or 0xFF then shows that the upper bits are dropped. The bench also models a takeover arbiter that refuses channels above 4, so both a zero and a nonzero result byte are exercised.

// File: rtl/spi_fb_pkg.sv
package spi_fb_pkg;
  typedef enum logic [3:0] {
    ST_CMD, ST_AHI, ST_ALO, ST_WR, ST_RD, ST_RNX, ST_VER, ST_ARG, ST_IGN
  } st_e;

  typedef enum logic [2:0] {K_WR, K_RD, K_SP, K_TK, K_PW} kind_e;

  localparam logic [7:0] OP_WRITE    = 8'h02;
  localparam logic [7:0] OP_READ     = 8'h03;
  localparam logic [7:0] OP_READNEXT = 8'h04;
  localparam logic [7:0] OP_LOC      = 8'h06;
  localparam logic [7:0] OP_SETPTR   = 8'h07;
  localparam logic [7:0] OP_VER      = 8'h08;
  localparam logic [7:0] OP_TAKE     = 8'h09;
  localparam logic [7:0] OP_POWER    = 8'h0B;
endpackage

// File: rtl/spi_fb_sync.sv
module spi_fb_sync #(
  parameter int          W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/spi_fb_shift.sv
module spi_fb_shift (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_act_i,
  input  logic       sclk_i,
  input  logic       mosi_i,
  input  logic [7:0] tx_load_i,
  output logic       byte_done_o,
  output logic [7:0] rx_byte_o,
  output logic       miso_o
);
  logic       sclk_q;
  logic [2:0] bit_cnt_q;
  logic [7:0] rx_sr_q, tx_sr_q;
  logic       rise, fall;

  assign rise   = sclk_i & ~sclk_q;
  assign fall   = ~sclk_i & sclk_q;
  assign miso_o = tx_sr_q[7];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q      <= 1'b0;
      bit_cnt_q   <= '0;
      rx_sr_q     <= '0;
      tx_sr_q     <= '0;
      byte_done_o <= 1'b0;
      rx_byte_o   <= '0;
    end else begin
      sclk_q      <= sclk_i;
      byte_done_o <= 1'b0;
      if (!cs_act_i) begin
        bit_cnt_q <= '0;
        rx_sr_q   <= '0;
        tx_sr_q   <= '0;
      end else begin
        if (rise) begin
          rx_sr_q   <= {rx_sr_q[6:0], mosi_i};
          bit_cnt_q <= bit_cnt_q + 3'd1;
          if (bit_cnt_q == 3'd7) begin
            byte_done_o <= 1'b1;
            rx_byte_o   <= {rx_sr_q[6:0], mosi_i};
          end
        end
        // load the next response byte on the fall that closes a byte
        if (fall) begin
          if (bit_cnt_q == 3'd0) tx_sr_q <= tx_load_i;
          else                   tx_sr_q <= {tx_sr_q[6:0], 1'b0};
        end
      end
    end
  end
endmodule

// File: rtl/spi_fb_cmd.sv
module spi_fb_cmd
  import spi_fb_pkg::*;
#(
  parameter int          ADDR_W      = 9,
  parameter logic [2:0]  SLOT_ID     = 3'd1,
  parameter logic        SLOT_IS_OUT = 1'b0,
  parameter logic [7:0]  PROTO_VER   = 8'd1,
  parameter logic [15:0] FW_VER      = 16'd1,
  parameter logic [7:0]  HW_REV      = 8'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_act_i,
  input  logic              byte_done_i,
  input  logic [7:0]        rx_byte_i,
  output logic [7:0]        tx_next_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              tk_req_o,
  output logic [7:0]        tk_chan_o,
  input  logic [7:0]        tk_result_i,
  output logic              bus_a_o,
  output logic              bus_b_o
);
  localparam logic [7:0] LOC_BYTE = {4'b0000, SLOT_ID, SLOT_IS_OUT};
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  st_e               st_q;
  kind_e             kind_q;
  logic [7:0]        ahi_q;
  logic [ADDR_W-1:0] addr_q, ptr_q;
  logic [1:0]        ver_idx_q;
  logic              rd_p1_q, rd_p2_q;
  logic [15:0]       a_full;
  logic [ADDR_W-1:0] a_new;

  assign a_full = {ahi_q, rx_byte_i};
  assign a_new  = a_full[ADDR_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_CMD;
      kind_q      <= K_WR;
      ahi_q       <= '0;
      addr_q      <= '0;
      ptr_q       <= '0;
      ver_idx_q   <= '0;
      rd_p1_q     <= 1'b0;
      rd_p2_q     <= 1'b0;
      tx_next_o   <= '0;
      mem_addr_o  <= '0;
      mem_wdata_o <= '0;
      mem_we_o    <= 1'b0;
      tk_req_o    <= 1'b0;
      tk_chan_o   <= '0;
      bus_a_o     <= 1'b0;
      bus_b_o     <= 1'b0;
    end else begin
      mem_we_o <= 1'b0;
      tk_req_o <= 1'b0;
      rd_p1_q  <= 1'b0;
      rd_p2_q  <= rd_p1_q;
      if (rd_p2_q)  tx_next_o <= mem_rdata_i;
      if (tk_req_o) tx_next_o <= tk_result_i;
      if (!cs_act_i) begin
        st_q      <= ST_CMD;
        tx_next_o <= '0;
        ver_idx_q <= '0;
        rd_p1_q   <= 1'b0;
        rd_p2_q   <= 1'b0;
      end else if (byte_done_i) begin
        tx_next_o <= '0;
        unique case (st_q)
          ST_CMD: begin
            unique case (rx_byte_i)
              OP_WRITE:  begin kind_q <= K_WR; st_q <= ST_AHI; end
              OP_READ:   begin kind_q <= K_RD; st_q <= ST_AHI; end
              OP_SETPTR: begin kind_q <= K_SP; st_q <= ST_AHI; end
              OP_TAKE:   begin kind_q <= K_TK; st_q <= ST_ARG; end
              OP_POWER:  begin kind_q <= K_PW; st_q <= ST_ARG; end
              OP_READNEXT: begin
                mem_addr_o <= ptr_q;
                rd_p1_q    <= 1'b1;
                st_q       <= ST_RNX;
              end
              OP_LOC: begin
                tx_next_o <= LOC_BYTE;
                st_q      <= ST_IGN;
              end
              OP_VER: begin
                tx_next_o <= PROTO_VER;
                ver_idx_q <= 2'd1;
                st_q      <= ST_VER;
              end
              default: st_q <= ST_IGN;
            endcase
          end
          ST_AHI: begin
            ahi_q <= rx_byte_i;
            st_q  <= ST_ALO;
          end
          ST_ALO: begin
            unique case (kind_q)
              K_WR: begin addr_q <= a_new; st_q <= ST_WR; end
              K_RD: begin
                addr_q     <= a_new;
                mem_addr_o <= a_new;
                rd_p1_q    <= 1'b1;
                st_q       <= ST_RD;
              end
              default: begin ptr_q <= a_new; st_q <= ST_IGN; end
            endcase
          end
          ST_WR: begin
            mem_addr_o  <= addr_q;
            mem_wdata_o <= rx_byte_i;
            mem_we_o    <= 1'b1;
            addr_q      <= addr_q + ONE;
          end
          ST_RD: begin
            addr_q     <= addr_q + ONE;
            mem_addr_o <= addr_q + ONE;
            rd_p1_q    <= 1'b1;
          end
          ST_RNX: begin
            ptr_q      <= ptr_q + ONE;
            mem_addr_o <= ptr_q + ONE;
            rd_p1_q    <= 1'b1;
          end
          ST_VER: begin
            unique case (ver_idx_q)
              2'd1:    tx_next_o <= FW_VER[15:8];
              2'd2:    tx_next_o <= FW_VER[7:0];
              default: tx_next_o <= HW_REV;
            endcase
            ver_idx_q <= ver_idx_q + 2'd1;
            if (ver_idx_q == 2'd3) st_q <= ST_IGN;
          end
          ST_ARG: begin
            if (kind_q == K_TK) begin
              tk_req_o  <= 1'b1;
              tk_chan_o <= rx_byte_i;
            end else if (rx_byte_i[0]) begin
              bus_b_o <= rx_byte_i[1];
            end else begin
              bus_a_o <= rx_byte_i[1];
            end
            st_q <= ST_IGN;
          end
          default: st_q <= ST_IGN;
        endcase
      end
    end
  end
endmodule

// File: rtl/spi_fb_engine.sv
module spi_fb_engine #(
  parameter int          ADDR_W      = 9,
  parameter logic [2:0]  SLOT_ID     = 3'd1,
  parameter logic        SLOT_IS_OUT = 1'b0,
  parameter logic [7:0]  PROTO_VER   = 8'd1,
  parameter logic [15:0] FW_VER      = 16'd1,
  parameter logic [7:0]  HW_REV      = 8'd0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              cs_ni,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  output logic              mem_we_o,
  input  logic [7:0]        mem_rdata_i,
  output logic              takeover_req_o,
  output logic [7:0]        takeover_chan_o,
  input  logic [7:0]        takeover_result_i,
  output logic              bus_a_on_o,
  output logic              bus_b_on_o
);
  logic [2:0] sync_q;
  logic       cs_act, byte_done;
  logic [7:0] rx_byte, tx_next;

  spi_fb_sync #(.W(3), .RST_VAL(3'b010)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({mosi_i, cs_ni, sclk_i}),
    .q_o   (sync_q)
  );

  assign cs_act = ~sync_q[1];

  spi_fb_shift u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .sclk_i     (sync_q[0]),
    .mosi_i     (sync_q[2]),
    .tx_load_i  (tx_next),
    .byte_done_o(byte_done),
    .rx_byte_o  (rx_byte),
    .miso_o     (miso_o)
  );

  spi_fb_cmd #(
    .ADDR_W(ADDR_W), .SLOT_ID(SLOT_ID), .SLOT_IS_OUT(SLOT_IS_OUT),
    .PROTO_VER(PROTO_VER), .FW_VER(FW_VER), .HW_REV(HW_REV)
  ) u_cmd (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cs_act_i   (cs_act),
    .byte_done_i(byte_done),
    .rx_byte_i  (rx_byte),
    .tx_next_o  (tx_next),
    .mem_addr_o (mem_addr_o),
    .mem_wdata_o(mem_wdata_o),
    .mem_we_o   (mem_we_o),
    .mem_rdata_i(mem_rdata_i),
    .tk_req_o   (takeover_req_o),
    .tk_chan_o  (takeover_chan_o),
    .tk_result_i(takeover_result_i),
    .bus_a_o    (bus_a_on_o),
    .bus_b_o    (bus_b_on_o)
  );
endmodule

// File: rtl/spi_fb_engine_chk.sv
module spi_fb_engine_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cs_act,
  input logic byte_done,
  input logic miso_o,
  input logic mem_we_o,
  input logic takeover_req_o,
  input logic bus_a_on_o,
  input logic bus_b_on_o
);
  assert_we_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |=> !mem_we_o);

  assert_we_after_byte_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we_o |-> $past(byte_done) && $past(cs_act));

  assert_tk_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_req_o |=> !takeover_req_o);

  assert_tk_after_byte_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    takeover_req_o |-> $past(byte_done));

  assert_bus_change_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({bus_a_on_o, bus_b_on_o}) |-> $past(byte_done));

  assert_idle_miso_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_act && $past(!cs_act)) |-> !miso_o);
endmodule

bind spi_fb_engine spi_fb_engine_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_act        (cs_act),
  .byte_done     (byte_done),
  .miso_o        (miso_o),
  .mem_we_o      (mem_we_o),
  .takeover_req_o(takeover_req_o),
  .bus_a_on_o    (bus_a_on_o),
  .bus_b_on_o    (bus_b_on_o)
);

// File: tb/spi_fb_engine_tb.sv
module spi_fb_engine_tb;
  localparam int HALF = 8;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
  logic       miso;
  logic [8:0] maddr;
  logic [7:0] mwdata, mrdata;
  logic       mwe;
  logic       tk_req;
  logic [7:0] tk_chan, tk_res;
  logic       bus_a, bus_b;
  logic [7:0] fb_mem [0:511];
  int         total = 0, bad = 0, we_cnt = 0, tk_cnt = 0;
  logic       done = 1'b0;

  always #5 clk = ~clk;

  spi_fb_engine #(
    .ADDR_W(9), .SLOT_ID(3'd3), .SLOT_IS_OUT(1'b1),
    .PROTO_VER(8'd1), .FW_VER(16'h02A5), .HW_REV(8'd3)
  ) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .mosi_i(mosi),
    .miso_o(miso), .mem_addr_o(maddr), .mem_wdata_o(mwdata), .mem_we_o(mwe),
    .mem_rdata_i(mrdata), .takeover_req_o(tk_req), .takeover_chan_o(tk_chan),
    .takeover_result_i(tk_res), .bus_a_on_o(bus_a), .bus_b_on_o(bus_b)
  );

  // external memory and arbiter models
  always_ff @(posedge clk) begin
    if (mwe) fb_mem[maddr] <= mwdata;
    mrdata <= fb_mem[maddr];
  end
  assign tk_res = (tk_chan > 8'd4) ? 8'h01 : 8'h00;

  always_ff @(posedge clk) begin
    if (mwe)    we_cnt <= we_cnt + 1;
    if (tk_req) tk_cnt <= tk_cnt + 1;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cs_begin();
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic cs_end();
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, input int n, output logic [7:0] r);
    r = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = d[i];
      repeat (HALF) @(negedge clk);
      r = {r[6:0], miso};
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
  endtask

  task automatic do_write(input logic [7:0] hi, input logic [7:0] lo,
                          input logic [7:0] d0, input logic [7:0] d1,
                          input logic [7:0] d2, input logic [7:0] d3, input int n);
    logic [7:0] r;
    logic [7:0] dv [4];
    dv = '{d0, d1, d2, d3};
    cs_begin();
    xfer(8'h02, 8, r); xfer(hi, 8, r); xfer(lo, 8, r);
    for (int i = 0; i < n; i++) xfer(dv[i], 8, r);
    cs_end();
  endtask

  task automatic t_reset();
    check("R1 miso", miso, 0);
    check("R1 we", mwe, 0);
    check("R1 tk_req", tk_req, 0);
    check("R1 buses", {bus_a, bus_b}, 0);
  endtask

  task automatic t_write_wrap();
    int w0 = we_cnt;
    do_write(8'hFF, 8'hFE, 8'hA1, 8'hB2, 8'hC3, 8'hD4, 4);
    check("R2 write count", we_cnt - w0, 4);
    check("R2 mem 1FE", fb_mem[9'h1FE], 8'hA1);
    check("R2 mem 1FF", fb_mem[9'h1FF], 8'hB2);
    check("R3 wrap write 000", fb_mem[9'h000], 8'hC3);
    check("R3 wrap write 001", fb_mem[9'h001], 8'hD4);
  endtask

  task automatic t_read_wrap();
    logic [7:0] r;
    logic [7:0] exp [4];
    exp = '{8'hA1, 8'hB2, 8'hC3, 8'hD4};
    cs_begin();
    xfer(8'h03, 8, r); check("R11 miso in opcode", r, 0);
    xfer(8'h03, 8, r); check("R11 miso in addr hi", r, 0);
    xfer(8'hFE, 8, r); check("R11 miso in addr lo", r, 0);
    for (int i = 0; i < 4; i++) begin
      xfer(8'h00, 8, r);
      check("R3 read burst", r, exp[i]);
    end
    cs_end();
  endtask

  task automatic t_readnext();
    logic [7:0] r;
    do_write(8'h00, 8'h05, 8'h11, 8'h22, 8'h33, 8'h44, 4);
    cs_begin();
    xfer(8'h07, 8, r); xfer(8'h00, 8, r); xfer(8'h05, 8, r);
    cs_end();
    cs_begin();
    xfer(8'h04, 8, r); check("R4 opcode byte", r, 0);
    xfer(8'h00, 8, r); check("R4 next 0", r, 8'h11);
    xfer(8'h00, 8, r); check("R4 next 1", r, 8'h22);
    cs_end();
    cs_begin();
    xfer(8'h04, 8, r);
    xfer(8'h00, 8, r); check("R4 persist 2", r, 8'h33);
    xfer(8'h00, 8, r); check("R4 persist 3", r, 8'h44);
    cs_end();
  endtask

  task automatic t_loc();
    logic [7:0] r;
    cs_begin();
    xfer(8'h06, 8, r);
    xfer(8'h00, 8, r); check("R5 location", r, 8'h07);
    xfer(8'h00, 8, r); check("R5 trailing", r, 8'h00);
    cs_end();
  endtask

  task automatic t_ver();
    logic [7:0] r;
    logic [7:0] exp [5];
    exp = '{8'h01, 8'h02, 8'hA5, 8'h03, 8'h00};
    cs_begin();
    xfer(8'h08, 8, r);
    for (int i = 0; i < 5; i++) begin
      xfer(8'h00, 8, r);
      check("R6 version byte", r, exp[i]);
    end
    cs_end();
  endtask

  task automatic t_takeover(input logic [7:0] ch, input logic [7:0] exp_res);
    logic [7:0] r;
    int t0 = tk_cnt;
    cs_begin();
    xfer(8'h09, 8, r); xfer(ch, 8, r);
    check("R11 miso in arg", r, 0);
    xfer(8'h00, 8, r); check("R7 result", r, exp_res);
    cs_end();
    check("R7 one request", tk_cnt - t0, 1);
    check("R7 channel", tk_chan, ch);
  endtask

  task automatic t_power(input logic [7:0] arg, input logic ea, input logic eb);
    logic [7:0] r;
    cs_begin();
    xfer(8'h0B, 8, r); xfer(arg, 8, r);
    cs_end();
    check("R8 bus state", {bus_a, bus_b}, {ea, eb});
  endtask

  task automatic t_ignore();
    logic [7:0] r, acc;
    logic [7:0] ops [5];
    int w0, t0;
    logic [1:0] b0;
    ops = '{8'h00, 8'h01, 8'h05, 8'h0C, 8'hFF};
    do_write(8'h00, 8'h30, 8'h5A, 8'h00, 8'h00, 8'h00, 1);
    w0 = we_cnt; t0 = tk_cnt; b0 = {bus_a, bus_b};
    for (int k = 0; k < 5; k++) begin
      acc = '0;
      cs_begin();
      xfer(ops[k], 8, r); acc |= r;
      xfer(8'h0B, 8, r); acc |= r;
      xfer(8'h03, 8, r); acc |= r;
      xfer(8'h30, 8, r); acc |= r;
      xfer(8'hAA, 8, r); acc |= r;
      cs_end();
      check("R9 miso zero", acc, 0);
    end
    check("R9 no writes", we_cnt - w0, 0);
    check("R9 no takeover", tk_cnt - t0, 0);
    check("R9 buses kept", {bus_a, bus_b}, b0);
    check("R9 mem kept", fb_mem[9'h030], 8'h5A);
  endtask

  task automatic t_abort();
    logic [7:0] r;
    int w0 = we_cnt;
    cs_begin();
    xfer(8'h02, 8, r); xfer(8'h00, 8, r); xfer(8'h30, 8, r);
    xfer(8'hF0, 4, r);
    cs_end();
    check("R10 partial byte dropped", we_cnt - w0, 0);
    cs_begin();
    xfer(8'h06, 5, r);
    cs_end();
    cs_begin();
    xfer(8'h03, 8, r); xfer(8'h00, 8, r); xfer(8'h30, 8, r);
    xfer(8'h00, 8, r); check("R10 fresh read", r, 8'h5A);
    cs_end();
    cs_begin();
    xfer(8'h06, 8, r); xfer(8'h00, 8, r);
    check("R10 fresh opcode", r, 8'h07);
    cs_end();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_write_wrap();
    t_read_wrap();
    t_readnext();
    t_loc();
    t_ver();
    t_takeover(8'h02, 8'h00);
    t_takeover(8'h07, 8'h01);
    t_power(8'h03, 1'b0, 1'b1);
    t_power(8'h02, 1'b1, 1'b1);
    t_power(8'h01, 1'b1, 1'b0);
    t_ignore();
    t_abort();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule